// File: doc/BRIEF.md
# Trap Return Status Update Unit

This unit carries out the two trap-return instructions of a hart with a machine level, a supervisor level and an optional hypervisor extension. When the execute stage raises a one-cycle return strobe together with a kind select (machine-level return or supervisor-level return), the unit checks whether the return is allowed. It then either produces a redirect PC with the rewritten status fields and a new privilege and virtualization mode, or produces an exception request with its cause code.

The unit holds the current privilege level and the virtualization flag itself. A synchronous reset puts the hart in machine mode with virtualization off. The status and hypervisor-status fields, and the two saved exception PCs, come in from the CSR file. The unit returns the rewritten status word one cycle after the strobe, together with a write pulse. The CSR file commits that word, and the front end follows the redirect. Swapping the hypervisor register banks and flushing the pipeline stay with those neighbours.

Privilege is encoded as user = 0, supervisor = 1, machine = 3. Exception causes are 0 for a misaligned fetch target, 2 for an illegal instruction and 22 for a virtual-instruction fault.

Top module: `trp_ret_unit`

## Requirements
- R1: After synchronous reset, `priv_o` = 3 and `virt_o` = 0, and `st_wr_o`, `redir_vld_o` and `exc_vld_o` are 0.
- R2: A machine-level return (`ret_kind` = 0) issued while the privilege is not 3 raises cause 2.
- R3: When `cfg_rvc` = 0 and bits [1:0] of the return target (`mepc_i` for kind 0, `sepc_i` for kind 1) are nonzero, the return raises cause 0. With `cfg_rvc` = 1 the same target is accepted.
- R4: An accepted machine-level return writes MIE = old MPIE, MPIE = 1, MPP = 0 and MPV = 0, and leaves every other field at its input value. The new privilege is the old MPP. The new virtualization flag is the old MPV when `cfg_hyp` = 1 and is unchanged otherwise. The redirect PC is `mepc_i`.
- R5: A machine-level return with `cfg_pmp_nz` = 0 and MPP not equal to 3 raises cause 2.
- R6: A supervisor-level return (`ret_kind` = 1) raises cause 2 when the privilege is 0, or when TSR = 1 and the privilege is not 3.
- R7: With `cfg_hyp` = 1, virtualization on and VTSR = 1, a supervisor-level return raises cause 22.
- R8: An accepted supervisor-level return with `cfg_hyp` = 1 and virtualization off writes SIE = old SPIE, SPIE = 1, SPP = 0 and SPV = 0. The new privilege is the old SPP, the new virtualization flag is the old SPV, and the redirect PC is `sepc_i`.
- R9: Any other accepted supervisor-level return writes SIE = old SPIE, SPIE = 1 and SPP = 0. It passes SPV through unchanged, sets the new privilege to the old SPP, leaves virtualization unchanged and redirects to `sepc_i`.
- R10: When an exception is raised, `st_wr_o` and `redir_vld_o` stay 0, and privilege and virtualization do not change.
- R11: All results appear in the cycle after the strobe edge as one-cycle pulses. Without a strobe there is no pulse and privilege and virtualization hold.
- R12: Checks rank in this order. For a machine-level return: privilege, then alignment, then the PMP rule. For a supervisor-level return: privilege, then alignment, then TSR, then VTSR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ret_req | input | 1 | Return strobe, one cycle per instruction |
| ret_kind | input | 1 | 0 = machine-level return, 1 = supervisor-level return |
| cfg_rvc | input | 1 | Compressed instructions present |
| cfg_hyp | input | 1 | Hypervisor extension present |
| cfg_pmp_nz | input | 1 | At least one PMP rule implemented |
| st_mie_i | input | 1 | Machine interrupt enable |
| st_mpie_i | input | 1 | Machine previous interrupt enable |
| st_mpp_i | input | 2 | Machine previous privilege |
| st_mpv_i | input | 1 | Machine previous virtualization |
| st_sie_i | input | 1 | Supervisor interrupt enable |
| st_spie_i | input | 1 | Supervisor previous interrupt enable |
| st_spp_i | input | 1 | Supervisor previous privilege |
| st_tsr_i | input | 1 | Trap supervisor return |
| hs_spv_i | input | 1 | Hypervisor-status previous virtualization |
| hs_vtsr_i | input | 1 | Hypervisor-status trap virtual supervisor return |
| mepc_i | input | XLEN | Machine exception PC |
| sepc_i | input | XLEN | Supervisor exception PC |
| priv_o | output | 2 | Current privilege level |
| virt_o | output | 1 | Current virtualization mode |
| st_wr_o | output | 1 | Status write pulse |
| nx_mie_o | output | 1 | New MIE |
| nx_mpie_o | output | 1 | New MPIE |
| nx_mpp_o | output | 2 | New MPP |
| nx_mpv_o | output | 1 | New MPV |
| nx_sie_o | output | 1 | New SIE |
| nx_spie_o | output | 1 | New SPIE |
| nx_spp_o | output | 1 | New SPP |
| nx_spv_o | output | 1 | New SPV |
| redir_vld_o | output | 1 | Redirect pulse |
| redir_pc_o | output | XLEN | Redirect target, 0 when no redirect |
| exc_vld_o | output | 1 | Exception request pulse |
| exc_cause_o | output | 5 | Exception cause code |

## Verification
The assertions check the following on every cycle:
- the reset state;
- that an exception pulse never comes with a write or a redirect and leaves privilege and virtualization unchanged;
- that no pulse appears without a strobe;
- that a machine-level return from below machine mode is refused;
- that a misaligned machine target faults without compressed support;
- that an accepted machine-level return always writes MPIE = 1, MPP = 0 and MPV = 0.

The values restored into privilege and virtualization, the split between the two supervisor-return update paths, the VTSR and PMP refusals, and the ranking of faults depend on a chain of earlier returns and configuration settings. Only the bench's scenarios exercise these, with the cycle-by-cycle reference model.

// File: rtl/trp_pkg.sv
package trp_pkg;

    localparam logic [1:0] LVL_USR = 2'd0;
    localparam logic [1:0] LVL_SUP = 2'd1;
    localparam logic [1:0] LVL_MCH = 2'd3;

    localparam int CAUSE_W = 5;
    localparam logic [CAUSE_W-1:0] CAUSE_MISAL = 5'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_ILL   = 5'd2;
    localparam logic [CAUSE_W-1:0] CAUSE_VIRT  = 5'd22;

    typedef enum logic {
        RK_MACH = 1'b0,
        RK_SUP  = 1'b1
    } ret_kind_e;

    typedef struct packed {
        logic       mie;
        logic       mpie;
        logic [1:0] mpp;
        logic       mpv;
        logic       sie;
        logic       spie;
        logic       spp;
        logic       spv;
    } stat_t;

endpackage

// File: rtl/trp_fault.sv
module trp_fault
    import trp_pkg::*;
(
    input  ret_kind_e            kind,
    input  logic [1:0]           priv,
    input  logic                 virt,
    input  logic                 cfg_rvc,
    input  logic                 cfg_hyp,
    input  logic                 cfg_pmp_nz,
    input  logic [1:0]           mpp,
    input  logic                 tsr,
    input  logic                 vtsr,
    input  logic [1:0]           tgt_lo,
    output logic                 fault,
    output logic [CAUSE_W-1:0]   cause
);

    logic misal;

    always_comb begin
        misal = !cfg_rvc && (tgt_lo != 2'b00);
        fault = 1'b0;
        cause = CAUSE_MISAL;
        if (kind == RK_MACH) begin
            if (priv != LVL_MCH) begin
                fault = 1'b1;
                cause = CAUSE_ILL;
            end else if (misal) begin
                fault = 1'b1;
                cause = CAUSE_MISAL;
            end else if (!cfg_pmp_nz && (mpp != LVL_MCH)) begin
                fault = 1'b1;
                cause = CAUSE_ILL;
            end
        end else begin
            if (priv < LVL_SUP) begin
                fault = 1'b1;
                cause = CAUSE_ILL;
            end else if (misal) begin
                fault = 1'b1;
                cause = CAUSE_MISAL;
            end else if (tsr && (priv != LVL_MCH)) begin
                fault = 1'b1;
                cause = CAUSE_ILL;
            end else if (cfg_hyp && virt && vtsr) begin
                fault = 1'b1;
                cause = CAUSE_VIRT;
            end
        end
    end

endmodule

// File: rtl/trp_upd.sv
module trp_upd
    import trp_pkg::*;
(
    input  ret_kind_e   kind,
    input  logic        virt,
    input  logic        cfg_hyp,
    input  stat_t       st_in,
    output stat_t       st_out,
    output logic [1:0]  priv_nx,
    output logic        virt_nx
);

    logic hyp_host;

    always_comb begin
        hyp_host = cfg_hyp && !virt;
        st_out   = st_in;
        priv_nx  = st_in.mpp;
        virt_nx  = virt;
        if (kind == RK_MACH) begin
            st_out.mie  = st_in.mpie;
            st_out.mpie = 1'b1;
            st_out.mpp  = LVL_USR;
            st_out.mpv  = 1'b0;
            priv_nx     = st_in.mpp;
            if (cfg_hyp) begin
                virt_nx = st_in.mpv;
            end
        end else begin
            st_out.sie  = st_in.spie;
            st_out.spie = 1'b1;
            st_out.spp  = 1'b0;
            priv_nx     = {1'b0, st_in.spp};
            if (hyp_host) begin
                st_out.spv = 1'b0;
                virt_nx    = st_in.spv;
            end
        end
    end

endmodule

// File: rtl/trp_ret_unit.sv
module trp_ret_unit
    import trp_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ret_req,
    input  logic               ret_kind,
    input  logic               cfg_rvc,
    input  logic               cfg_hyp,
    input  logic               cfg_pmp_nz,
    input  logic               st_mie_i,
    input  logic               st_mpie_i,
    input  logic [1:0]         st_mpp_i,
    input  logic               st_mpv_i,
    input  logic               st_sie_i,
    input  logic               st_spie_i,
    input  logic               st_spp_i,
    input  logic               st_tsr_i,
    input  logic               hs_spv_i,
    input  logic               hs_vtsr_i,
    input  logic [XLEN-1:0]    mepc_i,
    input  logic [XLEN-1:0]    sepc_i,
    output logic [1:0]         priv_o,
    output logic               virt_o,
    output logic               st_wr_o,
    output logic               nx_mie_o,
    output logic               nx_mpie_o,
    output logic [1:0]         nx_mpp_o,
    output logic               nx_mpv_o,
    output logic               nx_sie_o,
    output logic               nx_spie_o,
    output logic               nx_spp_o,
    output logic               nx_spv_o,
    output logic               redir_vld_o,
    output logic [XLEN-1:0]    redir_pc_o,
    output logic               exc_vld_o,
    output logic [CAUSE_W-1:0] exc_cause_o
);

    typedef struct packed {
        logic [1:0]         priv;
        logic               virt;
        logic               wr;
        stat_t              stat;
        logic               rv;
        logic [XLEN-1:0]    pc;
        logic               ev;
        logic [CAUSE_W-1:0] cause;
    } reg_t;

    reg_t r_d, r_q;

    ret_kind_e          kind;
    stat_t              st_cur;
    stat_t              st_new;
    logic [XLEN-1:0]    tgt_pc;
    logic               fault;
    logic [CAUSE_W-1:0] fault_cause;
    logic [1:0]         priv_nx;
    logic               virt_nx;

    assign kind   = ret_kind_e'(ret_kind);
    assign tgt_pc = (kind == RK_MACH) ? mepc_i : sepc_i;

    assign st_cur = '{mie:  st_mie_i,  mpie: st_mpie_i, mpp: st_mpp_i,
                      mpv:  st_mpv_i,  sie:  st_sie_i,  spie: st_spie_i,
                      spp:  st_spp_i,  spv:  hs_spv_i};

    trp_fault u_fault (
        .kind       (kind),
        .priv       (r_q.priv),
        .virt       (r_q.virt),
        .cfg_rvc    (cfg_rvc),
        .cfg_hyp    (cfg_hyp),
        .cfg_pmp_nz (cfg_pmp_nz),
        .mpp        (st_mpp_i),
        .tsr        (st_tsr_i),
        .vtsr       (hs_vtsr_i),
        .tgt_lo     (tgt_pc[1:0]),
        .fault      (fault),
        .cause      (fault_cause)
    );

    trp_upd u_upd (
        .kind    (kind),
        .virt    (r_q.virt),
        .cfg_hyp (cfg_hyp),
        .st_in   (st_cur),
        .st_out  (st_new),
        .priv_nx (priv_nx),
        .virt_nx (virt_nx)
    );

    always_comb begin
        r_d       = r_q;
        r_d.wr    = 1'b0;
        r_d.rv    = 1'b0;
        r_d.pc    = '0;
        r_d.ev    = 1'b0;
        r_d.cause = '0;
        if (ret_req) begin
            if (fault) begin
                r_d.ev    = 1'b1;
                r_d.cause = fault_cause;
            end else begin
                r_d.wr   = 1'b1;
                r_d.stat = st_new;
                r_d.priv = priv_nx;
                r_d.virt = virt_nx;
                r_d.rv   = 1'b1;
                r_d.pc   = tgt_pc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q      <= '0;
            r_q.priv <= LVL_MCH;
        end else begin
            r_q <= r_d;
        end
    end

    assign priv_o      = r_q.priv;
    assign virt_o      = r_q.virt;
    assign st_wr_o     = r_q.wr;
    assign nx_mie_o    = r_q.stat.mie;
    assign nx_mpie_o   = r_q.stat.mpie;
    assign nx_mpp_o    = r_q.stat.mpp;
    assign nx_mpv_o    = r_q.stat.mpv;
    assign nx_sie_o    = r_q.stat.sie;
    assign nx_spie_o   = r_q.stat.spie;
    assign nx_spp_o    = r_q.stat.spp;
    assign nx_spv_o    = r_q.stat.spv;
    assign redir_vld_o = r_q.rv;
    assign redir_pc_o  = r_q.pc;
    assign exc_vld_o   = r_q.ev;
    assign exc_cause_o = r_q.cause;

endmodule

// File: rtl/trp_ret_chk.sv
module trp_ret_chk (
    input logic       clk,
    input logic       rst,
    input logic       ret_req,
    input logic       ret_kind,
    input logic       cfg_rvc,
    input logic [1:0] mepc_lo,
    input logic [1:0] priv_o,
    input logic       virt_o,
    input logic       st_wr_o,
    input logic       nx_mpie_o,
    input logic [1:0] nx_mpp_o,
    input logic       nx_mpv_o,
    input logic       redir_vld_o,
    input logic       exc_vld_o,
    input logic [4:0] exc_cause_o
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (priv_o == 2'd3 && !virt_o && !st_wr_o && !redir_vld_o && !exc_vld_o));

    // R10
    exc_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        exc_vld_o |-> (!st_wr_o && !redir_vld_o && $stable(priv_o) && $stable(virt_o)));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ret_req |=> (!st_wr_o && !redir_vld_o && !exc_vld_o && $stable(priv_o) && $stable(virt_o)));

    // R2
    mret_priv_chk: assert property (@(posedge clk) disable iff (rst)
        (ret_req && !ret_kind && priv_o != 2'd3) |=> (exc_vld_o && exc_cause_o == 5'd2));

    // R3
    mret_misal_chk: assert property (@(posedge clk) disable iff (rst)
        (ret_req && !ret_kind && priv_o == 2'd3 && !cfg_rvc && mepc_lo != 2'b00)
        |=> (exc_vld_o && exc_cause_o == 5'd0));

    // R4
    mret_fields_chk: assert property (@(posedge clk) disable iff (rst)
        (ret_req && !ret_kind) |=> (exc_vld_o ||
            (st_wr_o && redir_vld_o && nx_mpie_o && nx_mpp_o == 2'd0 && !nx_mpv_o)));

endmodule

bind trp_ret_unit trp_ret_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ret_req     (ret_req),
    .ret_kind    (ret_kind),
    .cfg_rvc     (cfg_rvc),
    .mepc_lo     (mepc_i[1:0]),
    .priv_o      (priv_o),
    .virt_o      (virt_o),
    .st_wr_o     (st_wr_o),
    .nx_mpie_o   (nx_mpie_o),
    .nx_mpp_o    (nx_mpp_o),
    .nx_mpv_o    (nx_mpv_o),
    .redir_vld_o (redir_vld_o),
    .exc_vld_o   (exc_vld_o),
    .exc_cause_o (exc_cause_o)
);

// File: tb/tb_trp_ret_unit.sv
`timescale 1ns/1ps
module tb_trp_ret_unit;

    localparam int XLEN = 32;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst = 1'b1, ret_req = 1'b0, ret_kind = 1'b0;
    logic cfg_rvc = 1'b0, cfg_hyp = 1'b0, cfg_pmp_nz = 1'b1;
    logic st_mie_i = 0, st_mpie_i = 0, st_mpv_i = 0, st_sie_i = 0, st_spie_i = 0;
    logic st_spp_i = 0, st_tsr_i = 0, hs_spv_i = 0, hs_vtsr_i = 0;
    logic [1:0] st_mpp_i = 2'd3;
    logic [XLEN-1:0] mepc_i = '0, sepc_i = '0;

    logic [1:0] priv_o, nx_mpp_o;
    logic virt_o, st_wr_o, nx_mie_o, nx_mpie_o, nx_mpv_o, nx_sie_o, nx_spie_o;
    logic nx_spp_o, nx_spv_o, redir_vld_o, exc_vld_o;
    logic [XLEN-1:0] redir_pc_o;
    logic [4:0] exc_cause_o;

    trp_ret_unit #(.XLEN(XLEN)) dut (.*);

    int checks = 0, errors = 0;

    // reference model state
    int m_priv, m_virt, m_wr, m_rv, m_ev, m_cause;
    int m_mie, m_mpie, m_mpp, m_mpv, m_sie, m_spie, m_spp, m_spv;
    longint m_pc;

    task automatic model_reset();
        m_priv = 3; m_virt = 0; m_wr = 0; m_rv = 0; m_ev = 0; m_cause = 0; m_pc = 0;
        m_mie = 0; m_mpie = 0; m_mpp = 0; m_mpv = 0;
        m_sie = 0; m_spie = 0; m_spp = 0; m_spv = 0;
    endtask

    task automatic model_step();
        int fault;
        longint tgt;
        m_wr = 0; m_rv = 0; m_pc = 0; m_ev = 0; m_cause = 0;
        if (ret_req) begin
            fault = -1;
            if (!ret_kind) begin
                tgt = mepc_i;
                if (m_priv != 3) fault = 2;
                else if (!cfg_rvc && (tgt % 4) != 0) fault = 0;
                else if (!cfg_pmp_nz && st_mpp_i != 3) fault = 2;
            end else begin
                tgt = sepc_i;
                if (m_priv < 1) fault = 2;
                else if (!cfg_rvc && (tgt % 4) != 0) fault = 0;
                else if (st_tsr_i && m_priv != 3) fault = 2;
                else if (cfg_hyp && m_virt == 1 && hs_vtsr_i) fault = 22;
            end
            if (fault >= 0) begin
                m_ev = 1; m_cause = fault;
            end else begin
                m_wr = 1; m_rv = 1; m_pc = tgt;
                m_mie = st_mie_i; m_mpie = st_mpie_i; m_mpp = st_mpp_i; m_mpv = st_mpv_i;
                m_sie = st_sie_i; m_spie = st_spie_i; m_spp = st_spp_i; m_spv = hs_spv_i;
                if (!ret_kind) begin
                    m_mie = st_mpie_i; m_mpie = 1; m_mpp = 0; m_mpv = 0;
                    m_priv = st_mpp_i;
                    if (cfg_hyp) m_virt = st_mpv_i;
                end else begin
                    m_sie = st_spie_i; m_spie = 1; m_spp = 0;
                    m_priv = st_spp_i;
                    if (cfg_hyp && m_virt == 0) begin
                        m_spv = 0; m_virt = hs_spv_i;
                    end
                end
            end
        end
    endtask

    task automatic compare(input string tag);
        logic [63:0] act, exp;
        act = {priv_o, virt_o, st_wr_o, nx_mie_o, nx_mpie_o, nx_mpp_o, nx_mpv_o,
               nx_sie_o, nx_spie_o, nx_spp_o, nx_spv_o, redir_vld_o, exc_vld_o,
               exc_cause_o, redir_pc_o};
        exp = {2'(m_priv), 1'(m_virt), 1'(m_wr), 1'(m_mie), 1'(m_mpie), 2'(m_mpp),
               1'(m_mpv), 1'(m_sie), 1'(m_spie), 1'(m_spp), 1'(m_spv), 1'(m_rv),
               1'(m_ev), 5'(m_cause), 32'(m_pc)};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input string tag);
        rst = 1'b1; ret_req = 1'b0;
        @(posedge clk);
        @(posedge clk);
        model_reset();
        #1;
        compare(tag);
        rst = 1'b0;
    endtask

    task automatic cyc(input logic req, input logic kind, input string tag);
        ret_req  = req;
        ret_kind = kind;
        @(posedge clk);
        model_step();
        #1;
        compare(tag);
        ret_req = 1'b0;
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        do_reset("R1 reset");
        cyc(0, 0, "R11 idle");
        // SRET from machine with TSR set is allowed; go to supervisor
        st_tsr_i = 1; st_spp_i = 1; st_spie_i = 1; st_sie_i = 0; sepc_i = 32'h100;
        st_mie_i = 1; st_mpie_i = 0; st_mpp_i = 2'd1;
        cyc(1, 1, "R9 sret from machine");
        cyc(1, 0, "R2 R10 mret from supervisor");
        cyc(1, 1, "R6 R10 sret with tsr");
        st_tsr_i = 0; st_spp_i = 0; st_spie_i = 0; st_sie_i = 1; sepc_i = 32'h204;
        cyc(1, 1, "R9 sret to user");
        cyc(1, 1, "R6 sret from user");
        cyc(1, 0, "R2 mret from user");
        sepc_i = 32'h206;
        cyc(1, 1, "R12 priv before align");
        cyc(0, 1, "R11 idle hold");

        do_reset("R1 reset again");
        st_mpp_i = 2'd3; st_mpie_i = 1; mepc_i = 32'h102;
        cyc(1, 0, "R3 misaligned mret");
        cfg_rvc = 1;
        cyc(1, 0, "R3 R4 compressed target accepted");
        cfg_rvc = 0; mepc_i = 32'h400; cfg_pmp_nz = 0; st_mpp_i = 2'd1;
        cyc(1, 0, "R5 pmp refusal");
        mepc_i = 32'h401;
        cyc(1, 0, "R12 align before pmp");
        mepc_i = 32'h400; st_mpp_i = 2'd3;
        cyc(1, 0, "R5 pmp zero to machine ok");
        cfg_pmp_nz = 1; st_mpp_i = 2'd1; st_mpie_i = 0;
        cyc(1, 0, "R4 mret to supervisor");
        st_tsr_i = 1; sepc_i = 32'h302;
        cyc(1, 1, "R12 align before tsr");
        st_tsr_i = 0;

        do_reset("R1 reset hyp");
        cfg_hyp = 1; st_mpp_i = 2'd1; st_mpv_i = 1; st_mpie_i = 1; mepc_i = 32'h800;
        cyc(1, 0, "R4 mret into virtual supervisor");
        hs_vtsr_i = 1; sepc_i = 32'h900;
        cyc(1, 1, "R7 R10 vtsr fault");
        hs_vtsr_i = 0; hs_spv_i = 1; st_spp_i = 1; st_spie_i = 1;
        cyc(1, 1, "R9 sret virt on keeps spv");
        cyc(0, 0, "R11 idle virt");

        do_reset("R1 reset host");
        cfg_hyp = 1; hs_spv_i = 1; st_spp_i = 1; st_spie_i = 0; st_sie_i = 1;
        sepc_i = 32'hA00;
        cyc(1, 1, "R8 sret host path");
        hs_vtsr_i = 1; st_tsr_i = 1;
        cyc(1, 1, "R12 tsr before vtsr");
        hs_vtsr_i = 0; st_tsr_i = 0;

        do_reset("R1 reset nohyp");
        cfg_hyp = 0; st_mpv_i = 1; st_mpp_i = 2'd0; mepc_i = 32'hC00;
        cyc(1, 0, "R4 mret without hyp keeps virt");
        cyc(0, 0, "R11 final idle");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule